// File: doc/BRIEF.md
# Registered Multi-Phase Waveform Generator

This block drives seven timing waveforms locked to a free-running counter that repeats every 256 clocks. Four "rise" waveforms start each period low and go high one after another in the first few counts. Three "fall" waveforms start each period high and drop low one after another in the last few counts. Downstream logic uses them as staggered enable or strobe signals that must never glitch.

No output is decoded straight from the counter. Each waveform is a flip-flop with a set term and a clear term, in the manner of a JK register. A single wrap decode at the last count clears every rise register and sets every fall register. Only the earliest rise edge and the earliest fall edge are decoded from the counter. Each later edge is taken from the register of its neighbour, one clock behind, so the counter drives just three comparators.

Top module: `phase_wavegen`

## Requirements
- R1: While `en` is 1, `count_o` increases by one on every clock and wraps from 255 to 0.
- R2: While `rst` is 1, `count_o` is 0 after the next clock edge, `rise_o` is 4'b0000 and `fall_o` is 3'b111.
- R3: `rise_o[i]` (i = 0..3) is 0 while `count_o` is at most 4-i and 1 while `count_o` is at least 5-i. Bit 3 therefore rises at count 2 and bit 0 at count 5.
- R4: Every `rise_o` bit is 0 when `count_o` is 0, including just after the 255-to-0 wrap.
- R5: `fall_o[j]` (j = 0..2) is 1 while `count_o` is at most 251+j and 0 while `count_o` is at least 252+j. Bit 0 therefore drops at count 252 and bit 2 at count 254.
- R6: Every `fall_o` bit is 1 when `count_o` is 0.
- R7: While `en` is 0, `count_o`, `rise_o` and `fall_o` keep their values.
- R8: Over any 256 enabled clocks, each output bit changes exactly twice, once each way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; 0 freezes all state |
| rise_o | output | 4 | Rise waveforms; bit i goes high at count 5-i |
| fall_o | output | 3 | Fall waveforms; bit j goes low at count 252+j |
| count_o | output | 8 | Current period counter value |

## Verification
The assertions assume that `rst` is held for at least one clock edge before it is released, so that the counter and all waveform registers start from a consistent state. They also assume that `en` changes only between edges. The bench drives `rst` and `en` only on falling edges and keeps reset asserted for several clocks. It stops the block with `en` low both inside the rising chain and inside the falling chain, so the hold behaviour is exercised while edges are still propagating between neighbouring registers.

// File: rtl/phase_wavegen.sv
module phase_wavegen #(
  parameter int CNT_W       = 8,
  parameter int RISE_N      = 4,
  parameter int FALL_N      = 3,
  parameter int RISE_SET_AT = 1,
  parameter int FALL_CLR_AT = 251
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [RISE_N-1:0] rise_o,
  output logic [FALL_N-1:0] fall_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [CNT_W-1:0] LAST    = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] SET_PT  = CNT_W'(RISE_SET_AT);
  localparam logic [CNT_W-1:0] CLR_PT  = CNT_W'(FALL_CLR_AT);

  logic [CNT_W-1:0]  cnt_q;
  logic [RISE_N-1:0] rise_q, rise_j;
  logic [FALL_N-1:0] fall_q, fall_k;
  logic              wrap;

  assign wrap = (cnt_q == LAST);

  // set inputs: only the last rise bit decodes the counter, the rest chain
  assign rise_j[RISE_N-1] = (cnt_q == SET_PT);
  // clear inputs: only the first fall bit decodes the counter, the rest chain
  assign fall_k[0] = (cnt_q == CLR_PT);

  generate
    for (genvar i = 0; i < RISE_N-1; i++) begin : g_rise_chain
      assign rise_j[i] = rise_q[i+1];
    end
    for (genvar j = 1; j < FALL_N; j++) begin : g_fall_chain
      assign fall_k[j] = ~fall_q[j-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rise_q <= '0;
      fall_q <= '1;
    end else if (en) begin
      cnt_q <= cnt_q + ONE;
      for (int i = 0; i < RISE_N; i++) begin
        if (wrap)           rise_q[i] <= 1'b0;
        else if (rise_j[i]) rise_q[i] <= 1'b1;
      end
      for (int j = 0; j < FALL_N; j++) begin
        if (wrap)           fall_q[j] <= 1'b1;
        else if (fall_k[j]) fall_q[j] <= 1'b0;
      end
    end
  end

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign count_o = cnt_q;

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt_q == $past(cnt_q) + ONE);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q) && $stable(rise_q) && $stable(fall_q));

  a_r3_rise_order: assert property (@(posedge clk) disable iff (rst)
    (rise_q & ~{1'b1, rise_q[RISE_N-1:1]}) == '0);

  a_r5_fall_order: assert property (@(posedge clk) disable iff (rst)
    (fall_q & ~{1'b1, fall_q[FALL_N-1:1]}) == '0);

  a_r3_first_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_q[RISE_N-1]) |-> cnt_q == SET_PT + ONE);

  a_r5_first_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fall_q[0]) |-> cnt_q == CLR_PT + ONE);

  a_r4_r6_period_start: assert property (@(posedge clk) disable iff (rst)
    cnt_q == '0 |-> rise_q == '0 && fall_q == '1);

endmodule

// File: tb/tb_phase_wavegen.sv
module tb_phase_wavegen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] rise_o;
  logic [2:0] fall_o;
  logic [7:0] count_o;

  int n_chk  = 0;
  int n_bad  = 0;
  int cycles = 0;
  logic [7:0] exp_cnt = 8'd0;

  phase_wavegen dut (
    .clk(clk), .rst(rst), .en(en),
    .rise_o(rise_o), .fall_o(fall_o), .count_o(count_o)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] exp_rise(input logic [7:0] c);
    for (int i = 0; i < 4; i++) exp_rise[i] = (int'(c) >= 5 - i);
  endfunction

  function automatic logic [2:0] exp_fall(input logic [7:0] c);
    for (int j = 0; j < 3; j++) exp_fall[j] = (int'(c) <= 251 + j);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (count model %0d)", tag, act, exp, exp_cnt);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " count"}, 32'(count_o), 32'(exp_cnt));
    check({tag, " rise"},  32'(rise_o),  32'(exp_rise(exp_cnt)));
    check({tag, " fall"},  32'(fall_o),  32'(exp_fall(exp_cnt)));
  endtask

  // one clock; drive at negedge, check at the following negedge
  task automatic step(input logic e, input string tag);
    en = e;
    @(negedge clk);
    if (e) exp_cnt = exp_cnt + 8'd1;
    check_all(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    exp_cnt = 8'd0;
    check_all("R2 reset");
    rst = 1'b0;
  endtask

  task automatic t_full_period();
    for (int k = 0; k < 300; k++) step(1'b1, "R1 R3 R5 run");
  endtask

  task automatic t_wrap();
    while (exp_cnt != 8'd254) step(1'b1, "R1 approach");
    step(1'b1, "R5 count 255");
    step(1'b1, "R4 R6 wrap");
    check("R4 rise zero at wrap", 32'(rise_o), 32'd0);
    check("R6 fall ones at wrap", 32'(fall_o), 32'd7);
  endtask

  task automatic t_hold(input logic [7:0] at);
    logic [3:0] r; logic [2:0] f; logic [7:0] c;
    while (exp_cnt != at) step(1'b1, "R1 approach");
    r = rise_o; f = fall_o; c = count_o;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, "R7 hold");
      check("R7 rise stable", 32'(rise_o), 32'(r));
      check("R7 fall stable", 32'(fall_o), 32'(f));
      check("R7 count stable", 32'(count_o), 32'(c));
    end
    for (int k = 0; k < 4; k++) step(1'b1, "R7 resume");
  endtask

  task automatic t_edges();
    logic [3:0] pr; logic [2:0] pf;
    int tr[4]; int tf[3];
    for (int i = 0; i < 4; i++) tr[i] = 0;
    for (int j = 0; j < 3; j++) tf[j] = 0;
    while (exp_cnt != 8'd0) step(1'b1, "R1 approach");
    pr = rise_o; pf = fall_o;
    for (int k = 0; k < 256; k++) begin
      step(1'b1, "R8 period");
      for (int i = 0; i < 4; i++) if (rise_o[i] != pr[i]) tr[i]++;
      for (int j = 0; j < 3; j++) if (fall_o[j] != pf[j]) tf[j]++;
      pr = rise_o; pf = fall_o;
    end
    for (int i = 0; i < 4; i++) check("R8 rise toggles", 32'(tr[i]), 32'd2);
    for (int j = 0; j < 3; j++) check("R8 fall toggles", 32'(tf[j]), 32'd2);
  endtask

  task automatic t_reset_mid();
    while (exp_cnt != 8'd253) step(1'b1, "R1 approach");
    rst = 1'b1;
    @(negedge clk);
    exp_cnt = 8'd0;
    check_all("R2 reset mid-period");
    rst = 1'b0;
    for (int k = 0; k < 8; k++) step(1'b1, "R3 after reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_period();
    t_wrap();
    t_hold(8'd3);
    t_hold(8'd253);
    t_edges();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule